// File: doc/BRIEF.md
# Memory-Indirect Branch Target Fetcher

This block resolves the destination of a jump or call whose operand is an 8-bit memory-indirect pointer. A start pulse hands it the pointer and a mode select. The block widens the pointer with zeros, so every pointer names a slot in a fixed table of 256 bytes at the bottom of the address space. It then reads the slot through a 16-bit big-endian read port that uses a request/acknowledge handshake. It presents the branch target with a single-cycle valid pulse.

In the short mode the slot holds one word, and that word is the whole 16-bit target. In the wide mode the slot holds a longword that takes two word reads. The block drops the longword's top byte and keeps the low 24 bits as the target. Odd pointers and odd targets are both rounded down to the even address below them. The table shares space with the exception vectors, and the block gives that region no special treatment.

Top module: `mi_branch_fetch`

## Requirements
- R1: A synchronous active-high reset drives busy, rd_req and target_valid low and clears target to zero. The same holds after a reset that follows a completed fetch.
- R2: The first read address equals the pointer zero-extended to ADDR_W bits with bit 0 cleared. Every requested address is even and at most 0x0100.
- R3: With adv_mode=0 exactly one word is read. The target is {8'h00, word} with bit 0 forced to 0.
- R4: With adv_mode=1 two reads follow each other: the upper word at the even base address, then the lower word at base+2. For pointers 0xFE and 0xFF the second read is at 0x0100.
- R5: With adv_mode=1 the target is {upper word bits 7:0, lower word} with bit 0 forced to 0. Bits 15:8 of the upper word have no effect on the target.
- R6: rd_req and rd_addr stay stable until a cycle in which rd_ack is high. rd_data is taken only in that cycle.
- R7: target_valid is high for exactly one cycle, in the cycle after the last acknowledged read. busy is high from the cycle after an accepted start through the valid cycle.
- R8: A start pulse while busy is high is ignored. The fetch in progress keeps its addresses and its result.
- R9: target holds its value from one valid pulse until the next completed fetch or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a fetch (accepted only when idle) |
| ptr | input | PTR_W (8) | Absolute pointer from the instruction |
| adv_mode | input | 1 | 0: 16-bit word target, 1: 24-bit target from a longword |
| busy | output | 1 | Fetch in progress |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W (16) | Byte address of the word to read |
| rd_ack | input | 1 | Read acknowledge, data valid in the same cycle |
| rd_data | input | 16 | Big-endian read word |
| target | output | 24 | Resolved branch target |
| target_valid | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its default values: PTR_W=8 and ADDR_W=16. With these values the full pointer range is reachable, including the longword slot at 0xFE/0xFF whose second read crosses to 0x0100, so the top end of the table is exercised. The behavioural memory answers after a rotating wait of zero to two cycles, which tests the hold-until-acknowledge rule. The table bytes are arranged so that odd targets and non-zero reserved bytes appear.

// File: rtl/mibf_pkg.sv
package mibf_pkg;
  localparam int WORD_W = 16;
  localparam int TGT_W  = 24;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ_HI = 2'd1,
    ST_READ_LO = 2'd2,
    ST_DONE    = 2'd3
  } fetch_st_e;

  // Even-aligned table address from a pointer field.
  function automatic logic [15:0] slot_base(input logic [7:0] p);
    return {8'h00, p[7:1], 1'b0};
  endfunction

  // Build the target: the wide form keeps the low byte of the upper word.
  function automatic logic [TGT_W-1:0] build_target(input logic wide,
                                                    input logic [WORD_W-1:0] up,
                                                    input logic [WORD_W-1:0] low);
    logic [TGT_W-1:0] t;
    if (wide) t = {up[7:0], low};
    else      t = {8'h00, up};
    t[0] = 1'b0;
    return t;
  endfunction
endpackage

// File: rtl/mibf_ctrl.sv
module mibf_ctrl
  import mibf_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PTR_W-1:0] ptr,
  input  logic             adv_mode,
  input  logic             rd_ack,
  output fetch_st_e        state,
  output logic [PTR_W-1:0] ptr_q,
  output logic             adv_q,
  output logic             hi_done,
  output logic             finish_ev
);
  fetch_st_e state_nx;
  logic      accept;
  logic      lo_done;

  assign accept    = (state == ST_IDLE) && start;
  assign hi_done   = (state == ST_READ_HI) && rd_ack;
  assign lo_done   = (state == ST_READ_LO) && rd_ack;
  assign finish_ev = (hi_done && !adv_q) || lo_done;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (accept) state_nx = ST_READ_HI;
      ST_READ_HI: if (hi_done) state_nx = adv_q ? ST_READ_LO : ST_DONE;
      ST_READ_LO: if (lo_done) state_nx = ST_DONE;
      ST_DONE:    state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ptr_q <= '0;
      adv_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) begin
        ptr_q <= ptr;
        adv_q <= adv_mode;
      end
    end
  end

  // R8: a start while a fetch runs leaves the captured request untouched
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(ptr_q) && $stable(adv_q));
  // R4: the low-word phase exists only for the wide mode
  a_r4_lo_only_wide: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ_LO) |-> adv_q);
  // R7: the result phase lasts one cycle
  a_r7_done_once: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_IDLE));
endmodule

// File: rtl/mibf_addr_gen.sv
module mibf_addr_gen
  import mibf_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic [PTR_W-1:0]  ptr_q,
  input  logic              second,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_W = ADDR_W - PTR_W;
  logic [ADDR_W-1:0] base;

  generate
    if (PTR_W == 8 && ADDR_W == 16) begin : g_std
      assign base = slot_base(ptr_q);
    end else begin : g_gen
      assign base = {{PAD_W{1'b0}}, ptr_q[PTR_W-1:1], 1'b0};
    end
  endgenerate

  assign addr = second ? base + ADDR_W'(2) : base;
endmodule

// File: rtl/mibf_target.sv
module mibf_target
  import mibf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_q,
  input  logic              hi_done,
  input  logic              finish_ev,
  input  logic [WORD_W-1:0] rd_data,
  output logic [TGT_W-1:0]  target
);
  logic [WORD_W-1:0] hi_q;
  logic [WORD_W-1:0] up_word;

  assign up_word = adv_q ? hi_q : rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      target <= '0;
    end else begin
      if (hi_done) hi_q <= rd_data;
      if (finish_ev) target <= build_target(adv_q, up_word, rd_data);
    end
  end

  // R9: the result changes only when a fetch completes
  a_r9_target_hold: assert property (@(posedge clk) disable iff (rst)
    !finish_ev |=> $stable(target));
endmodule

// File: rtl/mi_branch_fetch.sv
module mi_branch_fetch
  import mibf_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              adv_mode,
  output logic              busy,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [15:0]       rd_data,
  output logic [23:0]       target,
  output logic              target_valid
);
  localparam int TBL_TOP = (1 << PTR_W);

  fetch_st_e        state;
  logic [PTR_W-1:0] ptr_q;
  logic             adv_q;
  logic             hi_done;
  logic             finish_ev;

  mibf_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .ptr(ptr), .adv_mode(adv_mode),
    .rd_ack(rd_ack), .state(state), .ptr_q(ptr_q), .adv_q(adv_q),
    .hi_done(hi_done), .finish_ev(finish_ev)
  );

  mibf_addr_gen #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_addr (
    .ptr_q(ptr_q), .second(state == ST_READ_LO), .addr(rd_addr)
  );

  mibf_target u_tgt (
    .clk(clk), .rst(rst), .adv_q(adv_q), .hi_done(hi_done),
    .finish_ev(finish_ev), .rd_data(rd_data), .target(target)
  );

  assign busy         = (state != ST_IDLE);
  assign rd_req       = (state == ST_READ_HI) || (state == ST_READ_LO);
  assign target_valid = (state == ST_DONE);

  // R6: an unanswered request holds its address
  a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
  // R2: requests stay inside the even-aligned table window
  a_r2_addr_window: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !rd_addr[0] && (rd_addr <= ADDR_W'(TBL_TOP)));
  // R7: one-cycle strobe, always inside the busy window
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    target_valid |=> !target_valid);
  a_r7_valid_busy: assert property (@(posedge clk) disable iff (rst)
    target_valid |-> busy);
  // R3/R5: targets are even; short-mode targets have a zero top byte
  a_r5_target_even: assert property (@(posedge clk) disable iff (rst)
    target_valid |-> !target[0]);
  a_r3_short_top_zero: assert property (@(posedge clk) disable iff (rst)
    target_valid && !adv_q |-> (target[23:16] == 8'h00));
endmodule

// File: tb/sim_mi_branch_fetch.sv
module sim_mi_branch_fetch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  ptr = 8'h00;
  logic        adv_mode = 1'b0;
  logic        busy, rd_req, target_valid;
  logic [15:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [15:0] rd_data = 16'hDEAD;
  logic [23:0] target;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit cmp_en = 0;

  byte unsigned mem [0:263];

  mi_branch_fetch u0 (
    .clk(clk), .rst(rst), .start(start), .ptr(ptr), .adv_mode(adv_mode),
    .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .target(target), .target_valid(target_valid)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_target(input int p, input bit wide);
    int a = p & 32'hFE;
    if (wide) return ((int'(mem[a+1]) << 16) | (int'(mem[a+2]) << 8) | int'(mem[a+3])) & 32'hFFFFFE;
    return ((int'(mem[a]) << 8) | int'(mem[a+1])) & 32'hFFFE;
  endfunction

  // behavioural reference: phase 0 idle, 1 first read, 2 second read, 3 result
  int m_ph = 0;
  int m_ptr = 0;
  bit m_adv = 0;
  int m_tgt = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_tgt = 0;
    end else begin
      case (m_ph)
        0: if (start) begin m_ptr = int'(ptr); m_adv = adv_mode; m_ph = 1; end
        1: if (rd_ack) begin
             if (m_adv) m_ph = 2;
             else begin m_tgt = ref_target(m_ptr, 0); m_ph = 3; end
           end
        2: if (rd_ack) begin m_tgt = ref_target(m_ptr, 1); m_ph = 3; end
        default: m_ph = 0;
      endcase
    end
  end

  // per-clock comparison at the falling edge
  always @(negedge clk) begin
    if (cmp_en) begin
      int ea;
      ea = (m_ptr & 32'hFE) + ((m_ph == 2) ? 2 : 0);
      check(busy === (m_ph != 0), "R7 busy", 32'(busy), 32'(m_ph != 0));
      check(rd_req === (m_ph == 1 || m_ph == 2), "R6 rd_req", 32'(rd_req), 32'(m_ph == 1 || m_ph == 2));
      if (m_ph == 1 || m_ph == 2)
        check(rd_addr === 16'(ea), "R2/R4 rd_addr", 32'(rd_addr), 32'(ea));
      check(target_valid === (m_ph == 3), "R7 target_valid", 32'(target_valid), 32'(m_ph == 3));
      check(target === 24'(m_tgt), "R3/R5/R9 target", 32'(target), 32'(m_tgt));
    end
  end

  // behavioural memory with a rotating wait of 0..2 cycles
  int wcnt = 0;
  int lat = 0;
  always @(negedge clk) begin
    if (rd_ack) begin
      rd_ack = 1'b0; rd_data = 16'hDEAD; wcnt = 0; lat = (lat + 1) % 3;
    end else if (rd_req) begin
      if (wcnt >= lat) begin
        rd_ack = 1'b1;
        rd_data = {8'(mem[int'(rd_addr)]), 8'(mem[int'(rd_addr) + 1])};
      end else wcnt++;
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic fetch(input logic [7:0] p, input bit wide, input bit poke);
    int n;
    int exp_t;
    exp_t = ref_target(int'(p), wide);
    @(negedge clk);
    start = 1'b1; ptr = p; adv_mode = wide;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R8: a second start with another pointer while busy
      @(negedge clk);
      start = 1'b1; ptr = p ^ 8'h40; adv_mode = ~wide;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!target_valid && n < 40) begin @(negedge clk); n++; end
    if (poke) check(target === 24'(exp_t), "R8 result of ignored start", 32'(target), 32'(exp_t));
    else if (wide) check(target === 24'(exp_t), "R5 wide target", 32'(target), 32'(exp_t));
    else check(target === 24'(exp_t), "R3 short target", 32'(target), 32'(exp_t));
    @(negedge clk);
    check(target_valid === 1'b0, "R7 strobe single cycle", 32'(target_valid), 32'd0);
    check(target === 24'(exp_t), "R9 target held", 32'(target), 32'(exp_t));
  endtask

  initial begin
    for (int i = 0; i < 264; i++) mem[i] = 8'((i * 73 + 29) & 255);
    mem[0] = 8'hA5; mem[1] = 8'h12; mem[2] = 8'h34; mem[3] = 8'h57;
    mem[16] = 8'h81; mem[17] = 8'h23;
    mem[32] = 8'hFF; mem[33] = 8'h9A; mem[34] = 8'hBC; mem[35] = 8'hDF;
    mem[254] = 8'h77; mem[255] = 8'h01; mem[256] = 8'h02; mem[257] = 8'h03;
    @(posedge clk);
    cmp_en = 1;
    @(negedge clk);
    check(busy === 1'b0 && rd_req === 1'b0, "R1 reset idle", {busy, rd_req}, 0);
    check(target_valid === 1'b0 && target === 24'h0, "R1 reset outputs", {7'd0, target_valid, target}, 0);
    @(negedge clk); rst = 1'b0;
    fetch(8'h10, 0, 0);
    fetch(8'h11, 0, 0);   // R2 odd pointer
    fetch(8'h00, 0, 0);
    fetch(8'h20, 1, 0);   // R5 non-zero reserved byte
    fetch(8'h21, 1, 0);
    fetch(8'hFE, 1, 0);   // R4 second read at 0x0100
    fetch(8'hFF, 1, 0);
    fetch(8'h00, 1, 0);
    fetch(8'hFF, 0, 0);
    fetch(8'h37, 1, 1);   // R8
    fetch(8'h52, 0, 1);
    for (int k = 0; k < 6; k++) fetch(8'((k * 43 + 5) & 255), k[0], 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(target === 24'h0 && busy === 1'b0, "R1 reset after fetch", {7'd0, busy, target}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule